// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is the management-side master of a two-wire PHY management bus. Host logic programs two registers. The control register holds a PHY address, a register address, a direction bit and a go/busy bit. The data register holds a 16-bit word. Setting the go bit while the block is idle launches one complete frame. The block derives the management clock (MDC) from the system clock with a fixed divider. It drives the bidirectional data line through three signals: an output value, an output enable and an input sample. When the frame is over it clears busy. On a read it then deposits the 16 bits returned by the PHY in the data register.

Control register layout (host write data and read-back): bits [4:0] register address, bits [9:5] PHY address, bit 10 direction (1 = write frame, 0 = read frame), bit 15 go/busy, all other bits 0. Each frame is 64 bit-times long, and each bit-time is `2*HALF_DIV` system cycles. The order on the wire is:
- 32 ones;
- start `0,1`;
- a 2-bit operation code (`0,1` for a write, `1,0` for a read);
- the PHY address, MSB first;
- the register address, MSB first;
- two turnaround bits;
- 16 data bits, MSB first.

The controller is one state machine with the states IDLE, PREAMBLE, HEADER, TURN, DATA and CAPTURE. IDLE goes to PREAMBLE on a go write. PREAMBLE goes to HEADER after bit 31, HEADER goes to TURN after bit 45 and TURN goes to DATA after bit 47. At the end of bit 63, DATA goes to IDLE for a write frame and to CAPTURE for a read frame. CAPTURE always returns to IDLE after one cycle. Each move out of a frame state happens on the cycle in which MDC falls.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy is 0, MDC is 0, the MDIO output enable is 0, and both the control read-back and the data register read 0.
- R2: A control write accepted in IDLE stores the PHY address, register address and direction at the layout given above. It starts a frame only when bit 15 is 1. With bit 15 at 0, busy and MDC stay 0.
- R3: With t the number of cycles after the clock edge that accepts the go write, MDC equals (t / HALF_DIV) mod 2 for t < 128*HALF_DIV. MDC is 0 whenever no frame runs.
- R4: Bit-times 0 to 31 carry logic one and bit-times 32 and 33 carry 0 then 1, with the driver enabled. Bit-time k spans t from 2*HALF_DIV*k to 2*HALF_DIV*(k+1)-1.
- R5: Bit-times 34 and 35 carry 0,1 for a write and 1,0 for a read. Bit-times 36 to 40 carry the PHY address, MSB first. Bit-times 41 to 45 carry the register address, MSB first.
- R6: In a write frame the driver stays enabled through bit-time 63. Bit-times 46 and 47 carry 1 then 0. Bit-times 48 to 63 carry data register bits 15 down to 0.
- R7: In a read frame the driver is disabled for bit-times 46 to 63. MDIO input is sampled on each rising MDC edge in bit-times 48 to 63, and the first sample becomes bit 15.
- R8: Whenever busy is 0 the MDIO output enable is 0.
- R9: Host writes to either register are dropped while busy is 1 and in the CAPTURE cycle. The frame on the line and the register read-back are unaffected.
- R10: A write frame clears busy at t = 128*HALF_DIV. The data register keeps its value.
- R11: A read frame clears busy at t = 128*HALF_DIV with the data register still at its old value. The captured word appears at t = 128*HALF_DIV+1.
- R12: A data register write accepted in IDLE reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | Register select: 0 control, 1 data |
| host_wdata | input | 16 | Host write data |
| ctrl_rdata | output | 16 | Control register read-back including busy |
| data_rdata | output | 16 | Data register read-back |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output driver enable |
| mdio_i | input | 1 | MDIO line sample |

## Verification
Write frames run with two address/data pairs. One uses alternating bit patterns and the other uses all-ones addresses with a single set data bit. Between them they separate a shift-order reversal from a wrong field offset in the header or data. Read frames return 0x8001 and 0xF0F0 from the bench PHY. These expose an off-by-one sample edge or a reversed capture order, and the ordering of busy against the data update at the end of the frame. One write frame and one read frame carry injected writes to both registers in mid-frame, which must leave the line and the read-back untouched. A control write with the go bit clear shows that field loading is separate from frame launch.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int BIT_CW     = $clog2(FRAME_BITS);
    localparam int PRE_LAST   = 31;
    localparam int HDR_LAST   = 45;
    localparam int TURN_LAST  = 47;
    localparam int DATA_LAST  = 63;

    localparam int REG_LSB    = 0;
    localparam int PHY_LSB    = 5;
    localparam int DIR_BIT    = 10;
    localparam int GO_BIT     = 15;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA,
        ST_CAPTURE
    } mdio_state_e;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic fall_stb,
    output logic rise_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          tick;

    assign tick     = run && (cnt_q == CNT_MAX);
    assign fall_stb = tick && mdc;
    assign rise_stb = tick && !mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_hostregs.sv
module mdio_hostregs
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic        sel,
    input  logic [15:0] wdata,
    input  logic        accept,
    input  logic        capture_en,
    input  logic [15:0] capture_data,
    output logic [4:0]  phy_q,
    output logic [4:0]  reg_q,
    output logic        wsel_q,
    output logic [15:0] data_q,
    output logic        start
);
    logic ctrl_wr;
    logic data_wr;

    assign ctrl_wr = we && !sel && accept;
    assign data_wr = we && sel && accept;
    assign start   = ctrl_wr && wdata[GO_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phy_q  <= '0;
            reg_q  <= '0;
            wsel_q <= 1'b0;
        end else if (ctrl_wr) begin
            phy_q  <= wdata[PHY_LSB +: 5];
            reg_q  <= wdata[REG_LSB +: 5];
            wsel_q <= wdata[DIR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (data_wr) begin
            data_q <= wdata;
        end else if (capture_en) begin
            data_q <= capture_data;
        end
    end

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(phy_q) && $stable(reg_q) && $stable(wsel_q)));
    // R9
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !capture_en) |=> $stable(data_q));
endmodule

// File: rtl/mdio_fsm.sv
module mdio_fsm
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        wsel,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wr_data,
    input  logic        fall_stb,
    input  logic        rise_stb,
    input  logic        mdio_i,
    output logic        run,
    output logic        busy,
    output logic        accept,
    output logic        capture_en,
    output logic [15:0] rx_data,
    output logic        mdio_o,
    output logic        mdio_oe
);
    mdio_state_e       state_q, state_d;
    logic [BIT_CW-1:0] bitcnt_q;
    logic [31:0]       tx_sr_q;
    logic [15:0]       rx_sr_q;
    logic [31:0]       tx_load;

    always_comb begin
        tx_load = {2'b01, (wsel ? OP_WRITE : OP_READ), phy, regad,
                   (wsel ? 2'b10 : 2'b00), (wsel ? wr_data : 16'h0000)};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall_stb && bitcnt_q == BIT_CW'(PRE_LAST))  state_d = ST_HEADER;
            ST_HEADER:   if (fall_stb && bitcnt_q == BIT_CW'(HDR_LAST))  state_d = ST_TURN;
            ST_TURN:     if (fall_stb && bitcnt_q == BIT_CW'(TURN_LAST)) state_d = ST_DATA;
            ST_DATA:     if (fall_stb && bitcnt_q == BIT_CW'(DATA_LAST))
                             state_d = wsel ? ST_IDLE : ST_CAPTURE;
            ST_CAPTURE:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            tx_sr_q  <= '0;
            rx_sr_q  <= '0;
        end else begin
            if (state_q == ST_IDLE)  bitcnt_q <= '0;
            else if (fall_stb)       bitcnt_q <= bitcnt_q + 1'b1;

            if (state_q == ST_PREAMBLE && fall_stb && bitcnt_q == BIT_CW'(PRE_LAST))
                tx_sr_q <= tx_load;
            else if (fall_stb && (state_q == ST_HEADER || state_q == ST_TURN || state_q == ST_DATA))
                tx_sr_q <= {tx_sr_q[30:0], 1'b0};

            if (rise_stb && state_q == ST_DATA)
                rx_sr_q <= {rx_sr_q[14:0], mdio_i};
        end
    end

    always_comb begin
        run        = 1'b0;
        accept     = 1'b0;
        capture_en = 1'b0;
        mdio_oe    = 1'b0;
        mdio_o     = 1'b1;
        unique case (state_q)
            ST_IDLE:     accept = 1'b1;
            ST_PREAMBLE: begin run = 1'b1; mdio_oe = 1'b1; end
            ST_HEADER:   begin run = 1'b1; mdio_oe = 1'b1; mdio_o = tx_sr_q[31]; end
            ST_TURN,
            ST_DATA:     begin run = 1'b1; mdio_oe = wsel; mdio_o = tx_sr_q[31]; end
            ST_CAPTURE:  capture_en = 1'b1;
            default:     accept = 1'b0;
        endcase
        busy = run;
    end

    assign rx_data = rx_sr_q;

    // R8
    idle_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);
    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wsel && bitcnt_q >= BIT_CW'(HDR_LAST + 1)) |-> !mdio_oe);
    // R4
    preamble_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bitcnt_q <= BIT_CW'(PRE_LAST)) |-> (mdio_o && mdio_oe));
    // R11
    busy_then_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |-> (!busy && $past(busy)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] ctrl_rdata,
    output logic [15:0] data_rdata,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        run, fall_stb, rise_stb;
    logic        accept, capture_en, start;
    logic [4:0]  phy_q, reg_q;
    logic        wsel_q;
    logic [15:0] data_q, rx_data;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mdc      (mdc),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    mdio_hostregs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (host_we),
        .sel          (host_sel),
        .wdata        (host_wdata),
        .accept       (accept),
        .capture_en   (capture_en),
        .capture_data (rx_data),
        .phy_q        (phy_q),
        .reg_q        (reg_q),
        .wsel_q       (wsel_q),
        .data_q       (data_q),
        .start        (start)
    );

    mdio_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wsel       (wsel_q),
        .phy        (phy_q),
        .regad      (reg_q),
        .wr_data    (data_q),
        .fall_stb   (fall_stb),
        .rise_stb   (rise_stb),
        .mdio_i     (mdio_i),
        .run        (run),
        .busy       (busy),
        .accept     (accept),
        .capture_en (capture_en),
        .rx_data    (rx_data),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe)
    );

    always_comb begin
        ctrl_rdata = '0;
        ctrl_rdata[REG_LSB +: 5] = reg_q;
        ctrl_rdata[PHY_LSB +: 5] = phy_q;
        ctrl_rdata[DIR_BIT]      = wsel_q;
        ctrl_rdata[GO_BIT]       = busy;
    end

    assign data_rdata = data_q;
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    localparam int H  = 3;
    localparam int FR = 128 * H;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] ctrl_rdata, data_rdata;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdio_master #(.HALF_DIV(H)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
        .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    function automatic logic exp_bit(input int bi, input logic ws,
                                     input logic [4:0] pa, input logic [4:0] ra,
                                     input logic [15:0] d);
        logic [1:0] op;
        op = ws ? 2'b01 : 2'b10;
        if (bi < 32)       return 1'b1;
        else if (bi == 32) return 1'b0;
        else if (bi == 33) return 1'b1;
        else if (bi < 36)  return op[35 - bi];
        else if (bi < 41)  return pa[40 - bi];
        else if (bi < 46)  return ra[45 - bi];
        else if (bi == 46) return 1'b1;
        else if (bi == 47) return 1'b0;
        else               return d[63 - bi];
    endfunction

    // Runs one frame; dat is the write data or the word the PHY returns.
    task automatic run_frame(input logic ws, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] dat, input logic inject,
                             input logic [15:0] prev);
        host_write(1'b0, {1'b1, 4'b0, ws, pa, ra});
        for (int t = 0; t <= FR + 2; t++) begin
            int bi;
            logic e_oe;
            bi = t / (2 * H);
            if (t < FR) begin
                check("R3 mdc", mdc, ((t / H) % 2));
                check("R10 busy high", busy, 1);
                e_oe = (bi < 46) || ws;
                if (bi >= 46) check(ws ? "R6 oe" : "R7 oe", mdio_oe, e_oe);
                else          check("R4 oe", mdio_oe, 1);
                if (e_oe) begin
                    if (bi < 34)      check("R4 bit", mdio_o, exp_bit(bi, ws, pa, ra, dat));
                    else if (bi < 46) check("R5 bit", mdio_o, exp_bit(bi, ws, pa, ra, dat));
                    else              check("R6 bit", mdio_o, exp_bit(bi, ws, pa, ra, dat));
                end
                check("R9 data held", data_rdata, prev);
            end else begin
                check(ws ? "R10 busy low" : "R11 busy low", busy, 0);
                check("R8 oe off", mdio_oe, 0);
                check("R3 mdc idle", mdc, 0);
            end
            if (!ws && t == FR)     check("R11 data old", data_rdata, prev);
            if (!ws && t == FR + 1) check("R7 captured", data_rdata, dat);
            if (ws && t == FR + 1)  check("R10 data kept", data_rdata, prev);
            mdio_i = (!ws && t < FR && bi >= 48) ? dat[63 - bi] : 1'b1;
            if (inject && t == 40) begin
                host_we = 1'b1; host_sel = 1'b0; host_wdata = {1'b1, 4'b0, ~ws, ~pa, ~ra};
            end else if (inject && t == 41) begin
                host_we = 1'b1; host_sel = 1'b1; host_wdata = ~prev;
            end else if (!ws && inject && t == FR) begin
                host_we = 1'b1; host_sel = 1'b1; host_wdata = 16'h1234;
            end else begin
                host_we = 1'b0;
            end
            @(negedge clk);
        end
        host_we = 1'b0;
        check("R9 ctrl kept", ctrl_rdata, {1'b0, 4'b0, ws, pa, ra});
        if (!ws) check("R9 capture cycle write dropped", data_rdata, dat);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 mdc", mdc, 0);
        check("R1 oe", mdio_oe, 0);
        check("R1 ctrl", ctrl_rdata, 0);
        check("R1 data", data_rdata, 0);

        host_write(1'b1, 16'hA5C3);
        check("R12 data readback", data_rdata, 16'hA5C3);
        host_write(1'b0, {1'b0, 4'b0, 1'b1, 5'h15, 5'h0A});
        check("R2 fields", ctrl_rdata, {1'b0, 4'b0, 1'b1, 5'h15, 5'h0A});
        repeat (2 * H) begin
            check("R2 no start busy", busy, 0);
            check("R2 no start mdc", mdc, 0);
            @(negedge clk);
        end

        run_frame(1'b1, 5'h15, 5'h0A, 16'hA5C3, 1'b1, 16'hA5C3);
        host_write(1'b1, 16'h0001);
        check("R12 data readback 2", data_rdata, 16'h0001);
        run_frame(1'b1, 5'h1F, 5'h1F, 16'h0001, 1'b0, 16'h0001);
        run_frame(1'b0, 5'h03, 5'h1C, 16'h8001, 1'b1, 16'h0001);
        run_frame(1'b0, 5'h0C, 5'h13, 16'hF0F0, 1'b0, 16'h8001);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule